// File: doc/BRIEF.md
# Segment Address Translator

This block turns a segment choice and an offset into a physical address. It holds four 16-bit segment registers: code, data, stack and extra. It works in one of two modes, selected by a mode input. In the legacy (real) mode the segment value is scaled by sixteen and added to a 16-bit offset. The sum is kept to 20 bits, so any address past 1 MiB folds back into the low megabyte. In protected mode the segment register holds a selector. The selector points into a 16-entry table of 32-bit segment bases. Whenever a segment register is written in this mode, the chosen base is copied into a per-segment cache. Translation reads that cache and never reads the table directly. The result is the cached base plus a 32-bit offset.

A small load sequencer handles the copy. It has two states. `LD_IDLE` is the rest state. `LD_FETCH` is the single cycle in which the cache entry is filled. A protected-mode segment write moves it from `LD_IDLE` to `LD_FETCH`. From `LD_FETCH` it returns to `LD_IDLE` unless another protected write arrives in that same cycle, in which case it stays in `LD_FETCH` for the new segment. While `LD_FETCH` is active, only requests for the segment being loaded see `req_ready` low. The translate response is registered.

Top module: `seg_xlate_top`

## Requirements
- R1: After reset `rsp_valid` is 0, `req_ready` is 1, the mode in use is real mode, and every segment register is 0. A real-mode request then returns its own low 16 offset bits as the address.
- R2: In real mode (`prot_mode`=0) the address is (segment×16 + offset[15:0]) mod 2^20, and `rsp_addr[31:20]` is 0.
- R3: In real mode a sum of 2^20 or more wraps. For example, segment FFFF with offset FFFF gives 0FFEF.
- R4: In real mode, offset bits 31:16 have no effect on the address.
- R5: A request accepted at a clock edge (`req_valid` and `req_ready` both 1) produces `rsp_valid`=1 with its address after that edge. After an edge with no accepted request, `rsp_valid` is 0.
- R6: In protected mode the address is (cached base + offset[31:0]) mod 2^32.
- R7: The table index is selector bits 15:3. Only index bits [3:0] (selector bits 6:3) address the 16 entries. Selector bits 2:0 and 15:7 have no effect.
- R8: A segment write in protected mode makes `req_ready` 0 for that segment during the cycle after the write. It stays 1 for the other segments. After that cycle, translations use the new base.
- R9: Writing a table entry does not change a segment's cached base until that segment register is written again in protected mode.
- R10: A segment write in real mode never drops `req_ready`.
- R11: `sr_sel` and `req_seg` use the codes 0=code, 1=data, 2=stack, 3=extra. Each of the four segments translates independently.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| prot_mode | input | 1 | 1 = protected mode, 0 = real mode |
| sr_we | input | 1 | Segment register write strobe |
| sr_sel | input | 2 | Segment register being written |
| sr_val | input | 16 | Value or selector to write |
| dt_we | input | 1 | Descriptor table write strobe |
| dt_idx | input | 4 | Table entry being written |
| dt_base | input | 32 | Base value for that entry |
| req_valid | input | 1 | Translate request |
| req_seg | input | 2 | Segment used by the request |
| req_off | input | 32 | Offset of the request |
| req_ready | output | 1 | Request can be accepted |
| rsp_valid | output | 1 | Response strobe |
| rsp_addr | output | 32 | Translated physical address |

## Verification
The hardest case to reach is the one-cycle `LD_FETCH` window. The stall exists only there, and only for the segment being loaded. To reach it, the bench writes a segment in protected mode and, in the very next cycle, moves `req_seg` between the loading segment and a neighbouring one, reading `req_ready` for each. The stale-cache case needs a particular order of events: load a segment, rewrite its table entry, translate (the old base must appear), then reload and translate again. Selectors are built with junk in the ignored bits. Real-mode sweeps cover the wrap at 1 MiB.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;
    typedef enum logic [1:0] {
        SEG_CODE  = 2'd0,
        SEG_DATA  = 2'd1,
        SEG_STACK = 2'd2,
        SEG_EXTRA = 2'd3
    } seg_id_e;

    typedef enum logic {
        LD_IDLE  = 1'b0,
        LD_FETCH = 1'b1
    } ld_state_e;
endpackage

// File: rtl/seg_desc_ram.sv
module seg_desc_ram #(
    parameter int DEPTH  = 16,
    parameter int BASE_W = 32,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [BASE_W-1:0] wdata,
    input  logic [AW-1:0]     raddr,
    output logic [BASE_W-1:0] rdata
);
    logic [BASE_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/seg_load_fsm.sv
module seg_load_fsm
    import seg_xlate_pkg::*;
#(
    parameter int NSEG   = 4,
    parameter int SEG_W  = 16,
    parameter int BASE_W = 32,
    parameter int DEPTH  = 16,
    localparam int SEL_W = $clog2(NSEG),
    localparam int AW    = $clog2(DEPTH),
    localparam int IDX_LSB = 3
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         prot_mode,
    input  logic                         sr_we,
    input  logic [SEL_W-1:0]             sr_sel,
    input  logic [SEG_W-1:0]             sr_val,
    output logic [AW-1:0]                tbl_raddr,
    input  logic [BASE_W-1:0]            tbl_rdata,
    output logic [NSEG-1:0][SEG_W-1:0]   seg_q,
    output logic [NSEG-1:0][BASE_W-1:0]  base_q,
    output logic                         busy,
    output logic [SEL_W-1:0]             busy_seg
);
    ld_state_e        state_q, state_d;
    logic [SEL_W-1:0] pend_q;
    logic             prot_wr;

    assign prot_wr = prot_mode && sr_we;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= LD_IDLE;
            pend_q  <= '0;
        end else begin
            state_q <= state_d;
            if (prot_wr) pend_q <= sr_sel;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LD_IDLE:  if (prot_wr) state_d = LD_FETCH;
            LD_FETCH: state_d = prot_wr ? LD_FETCH : LD_IDLE;
            default:  state_d = LD_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        busy      = 1'b0;
        busy_seg  = pend_q;
        tbl_raddr = seg_q[pend_q][IDX_LSB +: AW];
        unique case (state_q)
            LD_IDLE:  busy = 1'b0;
            LD_FETCH: busy = 1'b1;
            default:  busy = 1'b0;
        endcase
    end

    // Segment registers and descriptor cache
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seg_q  <= '0;
            base_q <= '0;
        end else begin
            if (state_q == LD_FETCH) base_q[pend_q] <= tbl_rdata;
            if (sr_we)               seg_q[sr_sel]  <= sr_val;
        end
    end
endmodule

// File: rtl/seg_addr_calc.sv
module seg_addr_calc #(
    parameter int SEG_W   = 16,
    parameter int BASE_W  = 32,
    parameter int SHIFT   = 4,
    localparam int REAL_W = SEG_W + SHIFT
) (
    input  logic              prot_mode,
    input  logic [SEG_W-1:0]  seg,
    input  logic [BASE_W-1:0] base,
    input  logic [BASE_W-1:0] off,
    output logic [BASE_W-1:0] addr
);
    logic [REAL_W-1:0] real_sum;

    always_comb begin
        real_sum = {seg, {SHIFT{1'b0}}} + REAL_W'(off[SEG_W-1:0]);
        if (prot_mode) addr = base + off;
        else           addr = BASE_W'(real_sum);
    end
endmodule

// File: rtl/seg_xlate_top.sv
module seg_xlate_top #(
    parameter int NSEG   = 4,
    parameter int SEG_W  = 16,
    parameter int BASE_W = 32,
    parameter int DEPTH  = 16,
    localparam int SEL_W = $clog2(NSEG),
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prot_mode,
    input  logic              sr_we,
    input  logic [SEL_W-1:0]  sr_sel,
    input  logic [SEG_W-1:0]  sr_val,
    input  logic              dt_we,
    input  logic [AW-1:0]     dt_idx,
    input  logic [BASE_W-1:0] dt_base,
    input  logic              req_valid,
    input  logic [SEL_W-1:0]  req_seg,
    input  logic [BASE_W-1:0] req_off,
    output logic              req_ready,
    output logic              rsp_valid,
    output logic [BASE_W-1:0] rsp_addr
);
    logic [AW-1:0]               tbl_raddr;
    logic [BASE_W-1:0]           tbl_rdata;
    logic [NSEG-1:0][SEG_W-1:0]  seg_q;
    logic [NSEG-1:0][BASE_W-1:0] base_q;
    logic                        busy;
    logic [SEL_W-1:0]            busy_seg;
    logic [BASE_W-1:0]           addr_c;

    seg_desc_ram #(.DEPTH(DEPTH), .BASE_W(BASE_W)) u_ram (
        .clk(clk), .rst_n(rst_n), .we(dt_we), .waddr(dt_idx),
        .wdata(dt_base), .raddr(tbl_raddr), .rdata(tbl_rdata)
    );

    seg_load_fsm #(.NSEG(NSEG), .SEG_W(SEG_W), .BASE_W(BASE_W), .DEPTH(DEPTH)) u_fsm (
        .clk(clk), .rst_n(rst_n), .prot_mode(prot_mode), .sr_we(sr_we),
        .sr_sel(sr_sel), .sr_val(sr_val), .tbl_raddr(tbl_raddr),
        .tbl_rdata(tbl_rdata), .seg_q(seg_q), .base_q(base_q),
        .busy(busy), .busy_seg(busy_seg)
    );

    seg_addr_calc #(.SEG_W(SEG_W), .BASE_W(BASE_W)) u_calc (
        .prot_mode(prot_mode), .seg(seg_q[req_seg]), .base(base_q[req_seg]),
        .off(req_off), .addr(addr_c)
    );

    assign req_ready = !(busy && (busy_seg == req_seg));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_addr  <= '0;
        end else begin
            rsp_valid <= req_valid && req_ready;
            if (req_valid && req_ready) rsp_addr <= addr_c;
        end
    end
endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk #(
    parameter int SEL_W  = 2,
    parameter int BASE_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              prot_mode,
    input logic              sr_we,
    input logic [SEL_W-1:0]  sr_sel,
    input logic              req_valid,
    input logic [SEL_W-1:0]  req_seg,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic [BASE_W-1:0] rsp_addr
);
    a_r5_rsp_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> rsp_valid);

    a_r5_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && req_ready) |=> !rsp_valid);

    a_r2_real_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (!prot_mode && req_valid && req_ready) |=> (rsp_addr[BASE_W-1:20] == '0));

    a_r8_stall_loading: assert property (@(posedge clk) disable iff (!rst_n)
        (prot_mode && sr_we) |=> (!req_ready || (req_seg != $past(sr_sel))));

    a_r10_stall_cause: assert property (@(posedge clk) disable iff (!rst_n)
        !req_ready |-> $past(prot_mode && sr_we));
endmodule

bind seg_xlate_top seg_xlate_chk #(.SEL_W(SEL_W), .BASE_W(BASE_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .prot_mode(prot_mode), .sr_we(sr_we),
    .sr_sel(sr_sel), .req_valid(req_valid), .req_seg(req_seg),
    .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_addr(rsp_addr)
);

// File: tb/seg_xlate_top_tb_top.sv
module seg_xlate_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        prot_mode = 1'b0;
    logic        sr_we = 1'b0;
    logic [1:0]  sr_sel = '0;
    logic [15:0] sr_val = '0;
    logic        dt_we = 1'b0;
    logic [3:0]  dt_idx = '0;
    logic [31:0] dt_base = '0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_seg = '0;
    logic [31:0] req_off = '0;
    logic        req_ready, rsp_valid;
    logic [31:0] rsp_addr;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    seg_xlate_top dut_i (
        .clk(clk), .rst_n(rst_n), .prot_mode(prot_mode), .sr_we(sr_we),
        .sr_sel(sr_sel), .sr_val(sr_val), .dt_we(dt_we), .dt_idx(dt_idx),
        .dt_base(dt_base), .req_valid(req_valid), .req_seg(req_seg),
        .req_off(req_off), .req_ready(req_ready), .rsp_valid(rsp_valid),
        .rsp_addr(rsp_addr)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] tbase(input int i);
        return (32'h9E37_79B9 * 32'(i + 1)) ^ 32'h00C0_FFEE;
    endfunction

    function automatic logic [15:0] mksel(input int i);
        return {9'(i * 23 + 5), 4'(i), 3'(i * 5)};
    endfunction

    task automatic xlate(input logic [1:0] seg, input logic [31:0] off,
                         input logic [31:0] exp, input string tag);
        @(negedge clk);
        chk("R5 idle rsp_valid", {31'b0, rsp_valid}, 32'd0);
        req_valid = 1'b1; req_seg = seg; req_off = off;
        #1;
        chk("R8/R10 ready", {31'b0, req_ready}, 32'd1);
        @(negedge clk);
        req_valid = 1'b0;
        chk("R5 rsp_valid", {31'b0, rsp_valid}, 32'd1);
        chk(tag, rsp_addr, exp);
    endtask

    task automatic wr_seg(input logic [1:0] seg, input logic [15:0] val);
        @(negedge clk);
        sr_we = 1'b1; sr_sel = seg; sr_val = val;
        @(negedge clk);
        sr_we = 1'b0;
        req_seg = seg; #1;
        chk(prot_mode ? "R8 stall own seg" : "R10 no stall",
            {31'b0, req_ready}, prot_mode ? 32'd0 : 32'd1);
        req_seg = seg ^ 2'd1; #1;
        chk("R8 other seg ready", {31'b0, req_ready}, 32'd1);
    endtask

    task automatic wr_tbl(input logic [3:0] idx, input logic [31:0] b);
        @(negedge clk);
        dt_we = 1'b1; dt_idx = idx; dt_base = b;
        @(negedge clk);
        dt_we = 1'b0;
    endtask

    initial begin
        #(20 * 150000);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [31:0] offs [6];
        offs = '{32'h0, 32'h1, 32'h7FFF, 32'hFFFF, 32'hABCD_1234, 32'hFFFF_FFF0};
        repeat (3) @(negedge clk);
        chk("R1 rsp_valid in reset", {31'b0, rsp_valid}, 32'd0);
        chk("R1 ready in reset", {31'b0, req_ready}, 32'd1);
        rst_n = 1'b1;
        xlate(2'd0, 32'h1234_5678, 32'h0000_5678, "R1 reset seg zero");

        // Real mode sweep
        for (int s = 0; s < 4; s++) begin
            for (int v = 0; v < 16; v++) begin
                logic [15:0] sv;
                sv = 16'(v * 16'h1111) ^ 16'(s * 3);
                wr_seg(2'(s), sv);
                for (int o = 0; o < 6; o++) begin
                    logic [19:0] e;
                    e = {sv, 4'b0} + {4'b0, offs[o][15:0]};
                    xlate(2'(s), offs[o], {12'b0, e}, "R2/R4/R11 real");
                end
            end
        end
        wr_seg(2'd3, 16'hFFFF);
        xlate(2'd3, 32'h0000_FFFF, 32'h0000_FFEF, "R3 wrap");
        xlate(2'd3, 32'hFFFF_0010, 32'h0000_0000, "R3/R4 wrap to zero");

        // Protected mode
        for (int i = 0; i < 16; i++) wr_tbl(4'(i), tbase(i));
        prot_mode = 1'b1;
        for (int i = 0; i < 16; i++) begin
            for (int s = 0; s < 4; s++) begin
                int k;
                k = (i + s * 5) % 16;
                wr_seg(2'(s), mksel(k));
                xlate(2'(s), 32'h0, tbase(k), "R6/R7 base");
                xlate(2'(s), 32'hFFFF_FFFF, tbase(k) + 32'hFFFF_FFFF, "R6 wrap");
                xlate(2'(s), 32'h8000_1234, tbase(k) + 32'h8000_1234, "R6/R11 off");
            end
        end

        // Stale cache until reload
        wr_seg(2'd1, mksel(9));
        wr_tbl(4'd9, 32'h1357_2468);
        xlate(2'd1, 32'h10, tbase(9) + 32'h10, "R9 stale base kept");
        wr_seg(2'd1, mksel(9));
        xlate(2'd1, 32'h10, 32'h1357_2478, "R9 reload new base");

        // Real mode again: uses segment value, no stall
        prot_mode = 1'b0;
        wr_seg(2'd2, 16'h1000);
        xlate(2'd2, 32'h0002_0005, 32'h0001_0005, "R2/R4 after mode switch");

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule